// File: doc/BRIEF.md
# Layer Overlap Collision Detector

This block sits in the display pipeline at the point where every graphics layer's pixel for the current screen position is present at once, one position per clock, before a priority mixer picks the visible one. It has no frame-buffer or memory-write side. It sees only what is being scanned out. Each layer has a per-pixel opacity flag. When two or more layers are opaque at the same position during active video, the block records which layers met.

Every layer owns a collision register. In the default vector mode, the register holds one bit per layer, and bit `n` of layer `k`'s register means "layer `k` was opaque where layer `n` was also opaque". A build parameter selects an "any" mode instead. In that mode each register collapses to a single bit meaning "this layer overlapped some other layer", which saves flops.

Bits are sticky. Software reads a register through a select/data port and clears one layer's register at a time with a clear strobe.

Top module: `col_detect`

## Requirements
- R1: After reset every collision register of every layer reads 0.
- R2: In vector mode, a clock with `pix_active`=1 where layers `k` and `n` (k≠n) both have their `pix_opaque` bit set leaves bit `n` of layer `k`'s register at 1 from the next clock on.
- R3: In vector mode, bit `k` of layer `k`'s register is never 1, because a layer does not collide with itself.
- R4: A clock in which at most one layer is opaque sets no bit in any register.
- R5: A clock with `pix_active`=0 sets no bit in any register, whatever the opacity flags.
- R6: A set bit stays 1 until a clear addresses its layer (`clr_en`=1, `clr_sel`=layer index). A clear of one layer leaves every other layer's register unchanged.
- R7: When a clear and a new collision hit the same layer on the same clock, that layer's register afterwards holds exactly the bits set by that clock's collision. The collision wins over the clear.
- R8: `rd_data` shows, in the same cycle, the register of the layer selected by `rd_sel`, with bit `n` at position `n`.
- R9: With `MODE` set to the "any" variant, each register is one bit wide. It becomes 1 after an active clock in which its layer and at least one other layer are opaque, and it obeys the same clear and blanking rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_active | input | 1 | High during the visible part of the line |
| pix_opaque | input | NUM_LAYERS | Per-layer opacity flag for the current pixel; bit k belongs to layer k |
| clr_en | input | 1 | Clear strobe for one layer's register |
| clr_sel | input | SEL_W | Layer whose register is cleared |
| rd_sel | input | SEL_W | Layer whose register is presented on rd_data |
| rd_data | output | REG_W | Selected collision register (NUM_LAYERS bits in vector mode, 1 bit in any mode) |

## Verification
On every cycle, the in-line properties check four things: a fresh overlap is captured on the next edge, bits survive until their own layer is cleared, a clear landing together with a hit leaves exactly the hit, and blanking adds no bit. They also check that no layer's self bit is ever set in vector mode. What only the bench scenarios show is the end-to-end picture seen through the read port. That covers exact register contents for chosen overlap patterns, that a clear of one layer spares its neighbours, and the single-bit variant built side by side with the vector one under identical stimulus.

// File: rtl/col_pkg.sv
package col_pkg;

    typedef enum logic {
        MODE_VECTOR = 1'b0,
        MODE_ANY    = 1'b1
    } col_mode_e;

    function automatic int sel_bits(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

    function automatic int reg_bits(input int n, input col_mode_e m);
        return (m == MODE_ANY) ? 1 : n;
    endfunction

endpackage

// File: rtl/col_hit_matrix.sv
module col_hit_matrix
    import col_pkg::*;
#(
    parameter int        NUM_LAYERS = 16,
    parameter col_mode_e MODE       = MODE_VECTOR,
    localparam int       REG_W      = reg_bits(NUM_LAYERS, MODE)
) (
    input  logic                                pix_active,
    input  logic [NUM_LAYERS-1:0]               pix_opaque,
    output logic [NUM_LAYERS-1:0][REG_W-1:0]    hit
);

    for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
        if (MODE == MODE_VECTOR) begin : g_vec
            for (genvar n = 0; n < NUM_LAYERS; n++) begin : g_other
                if (n == k) begin : g_self
                    assign hit[k][n] = 1'b0;
                end else begin : g_pair
                    assign hit[k][n] = pix_active & pix_opaque[k] & pix_opaque[n];
                end
            end
        end else begin : g_any
            logic [NUM_LAYERS-1:0] others;
            always_comb begin
                others    = pix_opaque;
                others[k] = 1'b0;
            end
            assign hit[k][0] = pix_active & pix_opaque[k] & (|others);
        end
    end

endmodule

// File: rtl/col_reg_bank.sv
module col_reg_bank #(
    parameter int NUM_LAYERS = 16,
    parameter int REG_W      = 16,
    parameter int SEL_W      = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_LAYERS-1:0][REG_W-1:0]    hit,
    input  logic                                clr_en,
    input  logic [SEL_W-1:0]                    clr_sel,
    output logic [NUM_LAYERS-1:0][REG_W-1:0]    bank
);

    typedef struct packed {
        logic [NUM_LAYERS-1:0][REG_W-1:0] bank;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int k = 0; k < NUM_LAYERS; k++) begin
            if (clr_en && (clr_sel == SEL_W'(k))) begin
                state_d.bank[k] = '0;
            end
            state_d.bank[k] = state_d.bank[k] | hit[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.bank;

    for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_chk
        AST_HIT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((bank[k] & $past(hit[k])) == $past(hit[k])));  // R2
        AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            !(clr_en && clr_sel == SEL_W'(k)) |=> ((bank[k] & $past(bank[k])) == $past(bank[k])));  // R6
        AST_CLEAR_YIELDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_sel == SEL_W'(k)) |=> (bank[k] == $past(hit[k])));  // R7
    end

endmodule

// File: rtl/col_read_mux.sv
module col_read_mux #(
    parameter int NUM_LAYERS = 16,
    parameter int REG_W      = 16,
    parameter int SEL_W      = 4
) (
    input  logic [NUM_LAYERS-1:0][REG_W-1:0]    bank,
    input  logic [SEL_W-1:0]                    rd_sel,
    output logic [REG_W-1:0]                    rd_data
);

    localparam int SLOTS = 1 << SEL_W;

    logic [SLOTS-1:0][REG_W-1:0] padded;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < NUM_LAYERS) begin : g_real
            assign padded[s] = bank[s];
        end else begin : g_pad
            assign padded[s] = '0;
        end
    end

    assign rd_data = padded[rd_sel];

endmodule

// File: rtl/col_detect.sv
module col_detect
    import col_pkg::*;
#(
    parameter int        NUM_LAYERS = 16,
    parameter col_mode_e MODE       = MODE_VECTOR,
    localparam int       SEL_W      = sel_bits(NUM_LAYERS),
    localparam int       REG_W      = reg_bits(NUM_LAYERS, MODE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_active,
    input  logic [NUM_LAYERS-1:0]   pix_opaque,
    input  logic                    clr_en,
    input  logic [SEL_W-1:0]        clr_sel,
    input  logic [SEL_W-1:0]        rd_sel,
    output logic [REG_W-1:0]        rd_data
);

    logic [NUM_LAYERS-1:0][REG_W-1:0] hit;
    logic [NUM_LAYERS-1:0][REG_W-1:0] bank;

    col_hit_matrix #(
        .NUM_LAYERS (NUM_LAYERS),
        .MODE       (MODE)
    ) u_hits (
        .pix_active (pix_active),
        .pix_opaque (pix_opaque),
        .hit        (hit)
    );

    col_reg_bank #(
        .NUM_LAYERS (NUM_LAYERS),
        .REG_W      (REG_W),
        .SEL_W      (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_en  (clr_en),
        .clr_sel (clr_sel),
        .bank    (bank)
    );

    col_read_mux #(
        .NUM_LAYERS (NUM_LAYERS),
        .REG_W      (REG_W),
        .SEL_W      (SEL_W)
    ) u_read (
        .bank    (bank),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    AST_BLANK_ADDS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |=> ((bank & ~$past(bank)) == '0));  // R5

    AST_SINGLE_LAYER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pix_opaque) |=> ((bank & ~$past(bank)) == '0));  // R4

    if (MODE == MODE_VECTOR) begin : g_self_chk
        for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_k
            AST_NO_SELF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                bank[k][k] == 1'b0);  // R3
        end
    end

endmodule

// File: tb/test_col_detect.sv
module test_col_detect;
    import col_pkg::*;

    localparam int NL = 16;
    localparam int SW = 4;

    typedef struct {
        int          unit;
        int          layer;
        logic [15:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_active = 1'b0;
    logic [NL-1:0] pix_opaque = '0;
    logic          clr_en = 1'b0;
    logic [SW-1:0] clr_sel = '0;
    logic [SW-1:0] rd_sel = '0;
    logic [NL-1:0] rd_data;
    logic [0:0]    rd_any;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [15:0] model_vec [NL];
    logic        model_any [NL];
    item_t       sb [$];

    always #4 clk = ~clk;

    col_detect #(.NUM_LAYERS(NL), .MODE(MODE_VECTOR)) i_col_detect (
        .clk(clk), .rst_n(rst_n), .pix_active(pix_active), .pix_opaque(pix_opaque),
        .clr_en(clr_en), .clr_sel(clr_sel), .rd_sel(rd_sel), .rd_data(rd_data));

    col_detect #(.NUM_LAYERS(NL), .MODE(MODE_ANY)) i_col_detect_any (
        .clk(clk), .rst_n(rst_n), .pix_active(pix_active), .pix_opaque(pix_opaque),
        .clr_en(clr_en), .clr_sel(clr_sel), .rd_sel(rd_sel), .rd_data(rd_any));

    // One pixel clock: drive at negedge, update the model to the state after the next edge.
    task automatic pixel(input logic act, input logic [NL-1:0] opq,
                         input logic clr, input int csel);
        @(negedge clk);
        pix_active = act;
        pix_opaque = opq;
        clr_en     = clr;
        clr_sel    = SW'(csel);
        for (int k = 0; k < NL; k++) begin
            if (clr && csel == k) begin
                model_vec[k] = '0;
                model_any[k] = 1'b0;
            end
            if (act && opq[k]) begin
                for (int n = 0; n < NL; n++) begin
                    if (n != k && opq[n]) begin
                        model_vec[k][n] = 1'b1;
                        model_any[k]    = 1'b1;
                    end
                end
            end
        end
    endtask

    // Idle the pixel path, select a layer and queue its expected value for both builds.
    task automatic read(input int layer, input string req);
        item_t it;
        @(negedge clk);
        pix_active = 1'b0;
        clr_en     = 1'b0;
        rd_sel     = SW'(layer);
        it.unit = 0; it.layer = layer; it.exp = model_vec[layer]; it.req = req;
        sb.push_back(it);
        it.unit = 1; it.exp = {15'd0, model_any[layer]}; it.req = {req, "/R9"};
        sb.push_back(it);
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < NL; k++) read(k, req);
    endtask

    // Monitor: outputs are stable while the bench idles the pixel path.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it  = sb.pop_front();
                got = (it.unit == 0) ? rd_data : {15'd0, rd_any};
                vectors++;
                if (got !== it.exp) begin
                    misses++;
                    $display("FAIL %s unit %0d layer %0d: got %h expected %h",
                             it.req, it.unit, it.layer, got, it.exp);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < NL; k++) begin
            model_vec[k] = '0;
            model_any[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        read_all("R1");

        // Overlap of layers 2 and 5; also self bit stays clear (R3)
        pixel(1'b1, 16'h0024, 1'b0, 0);
        read(2, "R2"); read(5, "R2"); read(0, "R3"); read(8, "R8");

        // A lone opaque layer sets nothing
        pixel(1'b1, 16'h0080, 1'b0, 0);
        read(7, "R4");

        // Blanking with every layer opaque sets nothing
        pixel(1'b0, 16'hFFFF, 1'b0, 0);
        read_all("R5");

        // Clear layer 2 only; layer 5 keeps its bit 2
        pixel(1'b0, 16'h0000, 1'b1, 2);
        read(2, "R6"); read(5, "R6");

        // Clear layer 5 while 5 and 9 overlap: the new hit survives
        pixel(1'b1, 16'h0220, 1'b1, 5);
        read(5, "R7"); read(9, "R7"); read(2, "R6");

        // Three-way overlap with a clear on an uninvolved layer
        pixel(1'b1, 16'h8401, 1'b1, 3);
        read(0, "R2"); read(10, "R2"); read(15, "R2"); read(3, "R6");

        // Every layer opaque: each register is all ones but its own bit
        pixel(1'b1, 16'hFFFF, 1'b0, 0);
        read_all("R3");

        // Clear everything, layer by layer, and confirm
        for (int k = 0; k < NL; k++) pixel(1'b0, '0, 1'b1, k);
        read_all("R6");

        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cycles = 0;
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule